// File: doc/BRIEF.md
# PHY Calibration and DLL Power Sequencer

This block is a hardware state machine that brings up the analog side of an eMMC-style PHY without firmware involvement. On a power-on request it first parks the calibration pad (power-down-bar low, DLL enable low). It then loads the fixed pad settings: a drive type of 50 ohm, output tap delay disabled and tap select 4. It holds the pad down for a settle interval and then releases it. It waits for the calibration-done status, applies a DLL frequency code derived from the card clock rate, enables the DLL and waits for the DLL-ready status. Each wait for a status input has its own timeout. An expired timeout aborts the sequence with an error code.

A power-off request runs only the first step, parking the pad, and then reports success. The card clock rate arrives in MHz. The frequency code is the rate divided by 50 MHz, rounded to the nearest integer and clamped to 0..3. A warning flag is raised when the unclamped quotient exceeds 3. All intervals are given in microseconds through parameters and are scaled by the reference clock frequency into cycles. One down-counter serves every interval.

Top module: `phy_pwr_seq`

## Requirements
- R1: While `rst` is sampled high, and after its release until a request arrives, every output is 0.
- R2: A request accepted in idle (`req_on` or `req_off` high; `req_on` wins if both are high) drives `pdb_o` and `dll_en_o` low, `busy_o` high, and `done_o` and `err_o` to 0, at the accepting edge.
- R3: A power-off request ends one cycle after acceptance, with `done_o` high and `busy_o` low. No pad setting or frequency code changes.
- R4: One cycle after a power-on request is accepted, `drv_type_o` = 6, `otap_en_o` = 0 and `otap_sel_o` = 4. These values are kept until reset.
- R5: During power-on, `pdb_o` stays low for exactly SETTLE_US*REF_MHZ+2 cycles after acceptance and then rises.
- R6: If calibration-done is not seen within CAL_TO_US*REF_MHZ+1 cycles after `pdb_o` rises, the sequence aborts. It drives `err_o` = 1, `pdb_o` low and `busy_o` low.
- R7: The frequency code is computed at acceptance from the round-to-nearest value of `rate_mhz`/50, clamped to 0..3. `rate_warn_o` is high when that quotient exceeds 3 on a power-on request, and low otherwise.
- R8: `dll_en_o` stays low from acceptance until calibration-done. The frequency code reaches `freq_sel_o` one cycle before `dll_en_o` rises.
- R9: If DLL-ready is not seen within DLL_TO_US*REF_MHZ+1 cycles after `dll_en_o` rises, the sequence aborts. It drives `err_o` = 2, and `pdb_o`, `dll_en_o` and `busy_o` low.
- R10: On DLL-ready, `done_o` goes high and `busy_o` low. `pdb_o` and `dll_en_o` stay high.
- R11: Requests that arrive while `busy_o` is high are ignored.
- R12: Both status inputs pass through a two-flop synchroniser. A status level set before edge k acts at edge k+2.
- R13: `done_o`, `err_o` and `rate_warn_o` hold their value until the next accepted request. `done_o` and a nonzero `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| req_on | input | 1 | Power-on request pulse |
| req_off | input | 1 | Power-off request pulse |
| rate_mhz | input | RATE_W | Card clock rate in MHz |
| cal_done_i | input | 1 | Calibration-done status (asynchronous) |
| dll_rdy_i | input | 1 | DLL-ready status (asynchronous) |
| pdb_o | output | 1 | Calibration pad power-down-bar |
| dll_en_o | output | 1 | DLL enable |
| freq_sel_o | output | 3 | DLL frequency code |
| drv_type_o | output | 3 | Pad drive type |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished successfully |
| err_o | output | 2 | 0 none, 1 calibration timeout, 2 DLL timeout |
| rate_warn_o | output | 1 | Unsupported clock rate warning |

## Verification
A request is visible on `busy_o` and `pdb_o` one cycle after it is driven. The pad settings follow one cycle later. `pdb_o` rises SETTLE_US*REF_MHZ+2 cycles after acceptance. A status level acts three sampling points after it is driven: two synchroniser flops and then the state register. A behavioural model in the bench applies the same delays with integer counters and a two-deep history of each status input. Outputs are compared with the model at every falling edge, away from the edge that updates them. Directed checks also count the low time of `pdb_o`, and the exact cycle in which `done_o` answers a DLL-ready.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PDOWN,
        ST_SETTLE,
        ST_CAL,
        ST_DLL_ON,
        ST_DLL_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_CAL  = 2'd1,
        ERR_DLL  = 2'd2
    } seq_err_e;

    localparam logic [2:0] DRV_50OHM    = 3'd6;
    localparam logic [3:0] OTAP_SEL_DEF = 4'd4;
    localparam int unsigned FREQ_STEP   = 50;
    localparam int unsigned FREQ_MAX    = 3;

    typedef struct packed {
        logic [2:0] code;
        logic       warn;
    } freq_pick_t;

    typedef struct packed {
        logic [2:0] drv;
        logic       otap_en;
        logic [3:0] otap_sel;
    } pad_cfg_t;

    function automatic freq_pick_t pick_freq(input logic [31:0] rate);
        freq_pick_t  r;
        logic [32:0] quot;
        quot   = ({1'b0, rate} + 33'(FREQ_STEP / 2)) / 33'(FREQ_STEP);
        r.warn = (quot > 33'(FREQ_MAX));
        r.code = r.warn ? 3'(FREQ_MAX) : quot[2:0];
        return r;
    endfunction

endpackage

// File: rtl/phy_pwr_seq_sync.sv
module phy_pwr_seq_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta;
        logic stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/phy_pwr_seq_timer.sv
module phy_pwr_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5/R6/R9: an idle count never wraps around
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
    import phy_pwr_seq_pkg::*;
#(
    parameter int REF_MHZ   = 100,
    parameter int SETTLE_US = 5,
    parameter int CAL_TO_US = 50,
    parameter int DLL_TO_US = 50000,
    parameter int RATE_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_on,
    input  logic              req_off,
    input  logic [RATE_W-1:0] rate_mhz,
    input  logic              cal_done_i,
    input  logic              dll_rdy_i,
    output logic              pdb_o,
    output logic              dll_en_o,
    output logic [2:0]        freq_sel_o,
    output logic [2:0]        drv_type_o,
    output logic              otap_en_o,
    output logic [3:0]        otap_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [1:0]        err_o,
    output logic              rate_warn_o
);
    localparam int SETTLE_CYC = SETTLE_US * REF_MHZ;
    localparam int CAL_CYC    = CAL_TO_US * REF_MHZ;
    localparam int DLL_CYC    = DLL_TO_US * REF_MHZ;
    localparam int MAX_A      = (SETTLE_CYC > CAL_CYC) ? SETTLE_CYC : CAL_CYC;
    localparam int MAX_CYC    = (MAX_A > DLL_CYC) ? MAX_A : DLL_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic             op_on;
    logic [2:0]       code_q;
    pad_cfg_t         pad;
    seq_err_e         err_q;
    logic [1:0]       stat_s;
    logic             cal_s, dll_s;
    logic             t_load, t_exp;
    logic [CNT_W-1:0] t_val;
    freq_pick_t       pick;
    logic             req_any;

    assign req_any = req_on | req_off;
    assign pick    = pick_freq(32'(rate_mhz));

    phy_pwr_seq_sync #(.WIDTH(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dll_rdy_i, cal_done_i}),
        .q   (stat_s)
    );
    assign cal_s = stat_s[0];
    assign dll_s = stat_s[1];

    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_PDOWN:  begin t_load = op_on; t_val = CNT_W'(SETTLE_CYC); end
            ST_SETTLE: begin t_load = t_exp; t_val = CNT_W'(CAL_CYC);    end
            ST_DLL_ON: begin t_load = 1'b1;  t_val = CNT_W'(DLL_CYC);    end
            default:   ;
        endcase
    end

    phy_pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            op_on       <= 1'b0;
            code_q      <= '0;
            pad         <= '0;
            err_q       <= ERR_NONE;
            pdb_o       <= 1'b0;
            dll_en_o    <= 1'b0;
            freq_sel_o  <= '0;
            busy_o      <= 1'b0;
            done_o      <= 1'b0;
            rate_warn_o <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_any) begin
                    op_on       <= req_on;
                    pdb_o       <= 1'b0;
                    dll_en_o    <= 1'b0;
                    busy_o      <= 1'b1;
                    done_o      <= 1'b0;
                    err_q       <= ERR_NONE;
                    code_q      <= pick.code;
                    rate_warn_o <= req_on & pick.warn;
                    state       <= ST_PDOWN;
                end
                ST_PDOWN: if (!op_on) begin
                    done_o <= 1'b1;
                    busy_o <= 1'b0;
                    state  <= ST_IDLE;
                end else begin
                    pad   <= '{drv: DRV_50OHM, otap_en: 1'b0, otap_sel: OTAP_SEL_DEF};
                    state <= ST_SETTLE;
                end
                ST_SETTLE: if (t_exp) begin
                    pdb_o <= 1'b1;
                    state <= ST_CAL;
                end
                ST_CAL: if (cal_s) begin
                    freq_sel_o <= code_q;
                    state      <= ST_DLL_ON;
                end else if (t_exp) begin
                    err_q  <= ERR_CAL;
                    pdb_o  <= 1'b0;
                    busy_o <= 1'b0;
                    state  <= ST_IDLE;
                end
                ST_DLL_ON: begin
                    dll_en_o <= 1'b1;
                    state    <= ST_DLL_WAIT;
                end
                ST_DLL_WAIT: if (dll_s) begin
                    done_o <= 1'b1;
                    busy_o <= 1'b0;
                    state  <= ST_IDLE;
                end else if (t_exp) begin
                    err_q    <= ERR_DLL;
                    pdb_o    <= 1'b0;
                    dll_en_o <= 1'b0;
                    busy_o   <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign drv_type_o = pad.drv;
    assign otap_en_o  = pad.otap_en;
    assign otap_sel_o = pad.otap_sel;
    assign err_o      = err_q;

    // R2: acceptance parks the pad and raises busy
    p_accept_parks_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && req_any) |=> (!pdb_o && !dll_en_o && busy_o));

    // R5: pad stays down while settling
    p_pdb_low_settle_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE) |-> !pdb_o);

    // R8: DLL off during calibration
    p_dll_off_cal_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETTLE || state == ST_CAL) |-> !dll_en_o);

    // R8: frequency code already in place when DLL turns on
    p_freq_first_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(dll_en_o) |-> $stable(freq_sel_o));

    // R11: no new sequence starts while one is running
    p_busy_ignores_r11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> (state != ST_PDOWN));

    // R13: success and error never reported together
    p_done_err_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o != 2'd0));
endmodule

// File: tb/phy_pwr_seq_test.sv
module phy_pwr_seq_test;
    localparam int N = 5;
    localparam int M = 50;
    localparam int D = 2000;
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_on = 1'b0, req_off = 1'b0;
    logic [11:0] rate = 12'd0;
    logic cal_i = 1'b0, dll_i = 1'b0;
    logic pdb, dll_en, otap_en, busy, done, warn;
    logic [2:0] fsel, drv;
    logic [3:0] osel;
    logic [1:0] err;

    int checks = 0, errors = 0, cycle = 0;
    bit started = 0, finished = 0;

    always #5 clk = ~clk;

    phy_pwr_seq #(.REF_MHZ(1), .SETTLE_US(N), .CAL_TO_US(M), .DLL_TO_US(D), .RATE_W(12)) uut (
        .clk(clk), .rst(rst), .req_on(req_on), .req_off(req_off), .rate_mhz(rate),
        .cal_done_i(cal_i), .dll_rdy_i(dll_i), .pdb_o(pdb), .dll_en_o(dll_en),
        .freq_sel_o(fsel), .drv_type_o(drv), .otap_en_o(otap_en), .otap_sel_o(osel),
        .busy_o(busy), .done_o(done), .err_o(err), .rate_warn_o(warn));

    // behavioural reference model
    int ph = 0, el = 0, q = 0;
    int m_pdb = 0, m_dll = 0, m_fs = 0, m_drv = 0, m_oen = 0, m_osel = 0;
    int m_busy = 0, m_done = 0, m_err = 0, m_warn = 0, m_code = 0, m_on = 0;
    int chist[$] = '{0, 0};
    int dhist[$] = '{0, 0};

    always @(posedge clk) begin
        int cs, ds;
        cs = chist.pop_front();
        ds = dhist.pop_front();
        chist.push_back(int'(cal_i));
        dhist.push_back(int'(dll_i));
        started = 1;
        cycle++;
        if (rst) begin
            chist = '{0, 0}; dhist = '{0, 0};
            ph = 0; m_pdb = 0; m_dll = 0; m_fs = 0; m_drv = 0; m_oen = 0; m_osel = 0;
            m_busy = 0; m_done = 0; m_err = 0; m_warn = 0; m_code = 0;
        end else begin
            case (ph)
                0: if (req_on || req_off) begin
                    m_on = int'(req_on); m_pdb = 0; m_dll = 0; m_busy = 1; m_done = 0; m_err = 0;
                    q = (int'(rate) + 25) / 50;
                    m_code = (q > 3) ? 3 : q;
                    m_warn = (req_on && q > 3) ? 1 : 0;
                    ph = 1;
                end
                1: if (m_on == 0) begin m_done = 1; m_busy = 0; ph = 0; end
                   else begin m_drv = 6; m_oen = 0; m_osel = 4; el = 0; ph = 2; end
                2: if (el == N) begin m_pdb = 1; el = 0; ph = 3; end else el++;
                3: if (cs != 0) begin m_fs = m_code; ph = 4; end
                   else if (el == M) begin m_err = 1; m_pdb = 0; m_busy = 0; ph = 0; end
                   else el++;
                4: begin m_dll = 1; el = 0; ph = 5; end
                5: if (ds != 0) begin m_done = 1; m_busy = 0; ph = 0; end
                   else if (el == D) begin m_err = 2; m_pdb = 0; m_dll = 0; m_busy = 0; ph = 0; end
                   else el++;
                default: ph = 0;
            endcase
        end
    end

    task automatic chk(input string req, input string nm, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, nm, got, exp, cycle);
        end
    endtask

    always @(negedge clk) if (started && !finished) begin
        chk("R5", "pdb", int'(pdb), m_pdb);
        chk("R8", "dll_en", int'(dll_en), m_dll);
        chk("R7", "freq_sel", int'(fsel), m_fs);
        chk("R4", "drv_type", int'(drv), m_drv);
        chk("R4", "otap_en", int'(otap_en), m_oen);
        chk("R4", "otap_sel", int'(osel), m_osel);
        chk("R11", "busy", int'(busy), m_busy);
        chk("R10", "done", int'(done), m_done);
        chk("R13", "err", int'(err), m_err);
        chk("R7", "warn", int'(warn), m_warn);
    end

    always @(posedge clk) if (cycle > LIMIT && !finished) begin
        finished = 1;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected at most %0d", cycle, LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic pulse(input bit on, input int r);
        @(negedge clk);
        rate = 12'(r);
        if (on) req_on = 1'b1; else req_off = 1'b1;
        @(negedge clk);
        req_on = 1'b0; req_off = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        int lowc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "pdb", int'(pdb), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "drv_type", int'(drv), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done", int'(done), 0);

        // R3: power-off ends one cycle after acceptance
        pulse(0, 100);
        chk("R2", "busy", int'(busy), 1);
        chk("R2", "pdb", int'(pdb), 0);
        @(negedge clk);
        chk("R3", "done", int'(done), 1);
        chk("R3", "drv_type", int'(drv), 0);

        // power-on, rate 100 -> code 2; measure settle (R5)
        pulse(1, 100);
        chk("R4", "drv_type", int'(drv), 0);
        lowc = 1;
        @(negedge clk);
        chk("R4", "drv_type", int'(drv), 6);
        chk("R4", "otap_sel", int'(osel), 4);
        while (!pdb) begin lowc++; @(negedge clk); end
        chk("R5", "pdb low cycles", lowc, N + 2);
        repeat (4) @(negedge clk);
        pulse(0, 0);  // R11: ignored while busy
        chk("R11", "busy", int'(busy), 1);
        chk("R11", "pdb", int'(pdb), 1);
        cal_i = 1'b1;
        while (!dll_en) @(negedge clk);
        chk("R8", "freq_sel", int'(fsel), 2);
        repeat (3) @(negedge clk);
        dll_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R12", "done early", int'(done), 0);
        @(negedge clk);
        chk("R12", "done", int'(done), 1);
        chk("R10", "dll_en", int'(dll_en), 1);
        chk("R10", "busy", int'(busy), 0);
        cal_i = 1'b0; dll_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R13", "done held", int'(done), 1);

        // R6: calibration timeout
        pulse(1, 50);
        chk("R13", "done cleared", int'(done), 0);
        wait_idle();
        chk("R6", "err", int'(err), 1);
        chk("R6", "pdb", int'(pdb), 0);

        // R9: DLL timeout with rate 200 -> warn, code 3
        pulse(1, 200);
        chk("R7", "warn", int'(warn), 1);
        while (!pdb) @(negedge clk);
        cal_i = 1'b1;
        wait_idle();
        chk("R9", "err", int'(err), 2);
        chk("R9", "dll_en", int'(dll_en), 0);
        chk("R7", "freq_sel", int'(fsel), 3);
        cal_i = 1'b0;
        repeat (3) @(negedge clk);

        // R7: rounding at the low and mid boundaries
        cal_i = 1'b1; dll_i = 1'b1;
        repeat (3) @(negedge clk);
        pulse(1, 24);
        wait_idle();
        chk("R7", "freq_sel rate24", int'(fsel), 0);
        chk("R7", "warn rate24", int'(warn), 0);
        pulse(1, 75);
        wait_idle();
        chk("R7", "freq_sel rate75", int'(fsel), 2);
        pulse(1, 174);
        wait_idle();
        chk("R7", "freq_sel rate174", int'(fsel), 3);
        chk("R7", "warn rate174", int'(warn), 0);

        // R3 after a completed power-on
        pulse(0, 0);
        @(negedge clk);
        chk("R3", "done", int'(done), 1);
        chk("R3", "pdb", int'(pdb), 0);
        chk("R3", "freq_sel kept", int'(fsel), 3);
        repeat (2) @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule